// File: doc/BRIEF.md
# Mode-Dependent Interrupt Priority Selector

This block holds one pending flag for each of seven interrupt sources and, when the core asks for an interrupt, names at most one source to deliver. The sources are numbered 0 to 6: trap-level-zero request, hypervisor timer match, external interrupt vector, cross-processor message, device message, resumable error, and soft interrupt. Any agent in the core posts a source by pulsing a strobe with the source number. The core's pipeline reads the any-pending flag as a cheap test before it arbitrates.

The choice is combinational on a snapshot of processor state: the hypervisor-privilege bit, the global interrupt enable, the trap-level-zero enable, the current trap level, the processor interrupt level (PIL) and the 16-bit soft-interrupt register. The priority order changes with the privilege mode. A soft interrupt at a low level gives way to a pending interrupt vector. The soft-interrupt flag stays pending while other soft levels are still set. Trap vectoring and register updates belong to the consumer.

Top module: `irq_prio_sel`

## Requirements
- R1: A synchronous active-high reset clears every pending flag. After reset `any_pend` is 0 and a take request delivers nothing.
- R2: A post with `post_idx` from 0 to 6 sets that source's flag on the next clock edge. Code values: 0 trap-level-zero, 1 timer match, 2 interrupt vector, 3 cross-processor message, 4 device message, 5 resumable error, 6 soft interrupt.
- R3: A post with `post_idx` equal to 7 drives `post_err` high in the same cycle and leaves every pending flag unchanged.
- R4: `any_pend` is high exactly when at least one pending flag is set.
- R5: With `hpriv` high, nothing is delivered unless `int_en` is high. When it is high, code 1 beats code 2 and no other source is delivered.
- R6: With `hpriv` low, code 0 is delivered only when `tl0_en` is high and `trap_lvl` is 0. It has the highest priority in that mode.
- R7: With `hpriv` low, code 1 is next in priority and is delivered even when `int_en` is low.
- R8: With `hpriv` low and `int_en` high, the remaining sources are ranked in this order: 3, 4, soft interrupt (6, or 2 in its place), then 5.
- R9: The soft level is the index of the highest set bit among bits 1 to 15 of `soft_reg`, or 0 if none is set. `take_lvl` shows it when code 6 is delivered and is 0 otherwise.
- R10: If soft interrupt is pending in its turn, its level is below 6 and code 2 is pending, code 2 is delivered instead.
- R11: Soft interrupt is delivered only if its level is strictly above `pil`. Otherwise arbitration goes on to code 5.
- R12: A delivery clears the delivered source's flag. For code 6 the flag is cleared only when `soft_reg`, with the delivered level's bit removed, has no set bit among bits 1 to 15.
- R13: If a post and a delivery hit the same source in one cycle, the post wins and the source stays pending.
- R14: `take_vld` is high only in a cycle where `take_req` is high and some source qualifies. Flags change through delivery only in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post strobe |
| post_idx | input | 3 | Source number being posted |
| take_req | input | 1 | Request to deliver one interrupt this cycle |
| hpriv | input | 1 | Hypervisor-privileged mode |
| int_en | input | 1 | Global interrupt enable |
| tl0_en | input | 1 | Enable for trap-level-zero requests |
| trap_lvl | input | 3 | Current trap level |
| pil | input | 4 | Processor interrupt level |
| soft_reg | input | 16 | Soft-interrupt register snapshot |
| any_pend | output | 1 | At least one source pending |
| post_err | output | 1 | Illegal source number posted |
| take_vld | output | 1 | A source is delivered this cycle |
| take_code | output | 3 | Code of the delivered source |
| take_lvl | output | 4 | Soft level of a delivered soft interrupt |

## Verification
On every cycle the assertions check several rules. In hypervisor mode only the timer or vector source may win. A trap-level-zero win needs its enable and trap level 0. A soft win needs a level above PIL. A vector outside hypervisor mode wins only by pre-empting a low soft level. At most one flag clears per cycle. A legal post is visible on the next cycle. An illegal post changes nothing. The reported soft level is the top set bit.

Only the bench's scenarios can show the full ordering across modes. They also show the soft flag staying pending while other levels remain set, and a post overriding a simultaneous clear. These come from sequences of posts and takes checked against a reference model.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int NUM_SRC = 7;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        SRC_TL0  = 3'd0,
        SRC_HTMR = 3'd1,
        SRC_VEC  = 3'd2,
        SRC_CPUQ = 3'd3,
        SRC_DEVQ = 3'd4,
        SRC_RERR = 3'd5,
        SRC_SOFT = 3'd6
    } irq_src_e;

    localparam int IX_TL0  = 0;
    localparam int IX_HTMR = 1;
    localparam int IX_VEC  = 2;
    localparam int IX_CPUQ = 3;
    localparam int IX_DEVQ = 4;
    localparam int IX_RERR = 5;
    localparam int IX_SOFT = 6;

endpackage

// File: rtl/irq_soft_lvl.sv
module irq_soft_lvl #(
    parameter int SOFT_W = 16,
    parameter int LVL_W  = $clog2(SOFT_W)
) (
    input  logic [SOFT_W-1:0] vec,
    output logic [LVL_W-1:0]  lvl
);
    // Highest set bit among 1..SOFT_W-1; bit 0 never counts.
    always_comb begin
        lvl = '0;
        for (int i = 1; i < SOFT_W; i++) begin
            if (vec[i]) lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_sel_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int IDX_W = CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             post_vld,
    input  logic [IDX_W-1:0] post_idx,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend,
    output logic             post_err
);
    logic             post_ok;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] pend_n;

    assign post_ok  = post_vld && (int'(post_idx) < N_SRC);
    assign post_err = post_vld && !post_ok;

    always_comb begin
        set_vec = '0;
        if (post_ok) set_vec[post_idx] = 1'b1;
    end

    // A post in the same cycle as a clear on that source wins.
    assign pend_n = (pend & ~clr) | set_vec;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_n;
    end

    p_post_sets_r2: assert property (@(posedge clk) disable iff (rst)
        post_ok |=> pend[$past(post_idx)]);

    p_bad_post_inert_r3: assert property (@(posedge clk) disable iff (rst)
        (post_vld && !post_ok && clr == '0) |=> $stable(pend));

    p_clear_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_sel_pkg::*;
#(
    parameter int N_SRC   = NUM_SRC,
    parameter int LVL_W   = 4,
    parameter int PIL_W   = 4,
    parameter int TL_W    = 3,
    parameter int VEC_LVL = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pend,
    input  logic             take_req,
    input  logic             hpriv,
    input  logic             int_en,
    input  logic             tl0_en,
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic [PIL_W-1:0] pil,
    input  logic [LVL_W-1:0] soft_lvl,
    input  logic             soft_more,
    output logic             grant,
    output irq_src_e         code,
    output logic [N_SRC-1:0] clr
);
    logic found;
    logic soft_low;

    assign soft_low = soft_lvl < LVL_W'(VEC_LVL);

    always_comb begin
        found = 1'b0;
        code  = SRC_TL0;
        if (hpriv) begin
            if (int_en) begin
                if (pend[IX_HTMR]) begin
                    found = 1'b1; code = SRC_HTMR;
                end else if (pend[IX_VEC]) begin
                    found = 1'b1; code = SRC_VEC;
                end
            end
        end else begin
            if (pend[IX_TL0] && tl0_en && trap_lvl == '0) begin
                found = 1'b1; code = SRC_TL0;
            end else if (pend[IX_HTMR]) begin
                found = 1'b1; code = SRC_HTMR;
            end else if (int_en) begin
                if (pend[IX_CPUQ]) begin
                    found = 1'b1; code = SRC_CPUQ;
                end else if (pend[IX_DEVQ]) begin
                    found = 1'b1; code = SRC_DEVQ;
                end else if (pend[IX_SOFT] && soft_low && pend[IX_VEC]) begin
                    found = 1'b1; code = SRC_VEC;
                end else if (pend[IX_SOFT] && (soft_lvl > LVL_W'(pil))) begin
                    found = 1'b1; code = SRC_SOFT;
                end else if (pend[IX_RERR]) begin
                    found = 1'b1; code = SRC_RERR;
                end
            end
        end
    end

    assign grant = take_req && found;

    for (genvar g = 0; g < N_SRC; g++) begin : g_clr
        if (g == IX_SOFT) begin : g_soft
            assign clr[g] = grant && (int'(code) == g) && !soft_more;
        end else begin : g_plain
            assign clr[g] = grant && (int'(code) == g);
        end
    end

    p_hpriv_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (found && hpriv) |-> (int_en && (code == SRC_HTMR || code == SRC_VEC)));

    p_tl0_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (found && code == SRC_TL0) |-> (!hpriv && tl0_en && trap_lvl == '0));

    p_vec_preempt_r10: assert property (@(posedge clk) disable iff (rst)
        (found && !hpriv && code == SRC_VEC) |-> (pend[IX_SOFT] && soft_low));

    p_soft_above_pil_r11: assert property (@(posedge clk) disable iff (rst)
        (found && code == SRC_SOFT) |-> (soft_lvl > LVL_W'(pil)));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_sel_pkg::*;
#(
    parameter int SOFT_W  = 16,
    parameter int TL_W    = 3,
    parameter int PIL_W   = 4,
    parameter int VEC_LVL = 6,
    localparam int LVL_W  = $clog2(SOFT_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_vld,
    input  logic [CODE_W-1:0] post_idx,
    input  logic              take_req,
    input  logic              hpriv,
    input  logic              int_en,
    input  logic              tl0_en,
    input  logic [TL_W-1:0]   trap_lvl,
    input  logic [PIL_W-1:0]  pil,
    input  logic [SOFT_W-1:0] soft_reg,
    output logic              any_pend,
    output logic              post_err,
    output logic              take_vld,
    output logic [CODE_W-1:0] take_code,
    output logic [LVL_W-1:0]  take_lvl
);
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic [LVL_W-1:0]   soft_lvl;
    logic [LVL_W-1:0]   rest_lvl;
    logic [SOFT_W-1:0]  soft_rest;
    logic               grant;
    irq_src_e           code;

    irq_soft_lvl #(.SOFT_W(SOFT_W), .LVL_W(LVL_W)) i_lvl_now (
        .vec (soft_reg),
        .lvl (soft_lvl)
    );

    assign soft_rest = soft_reg & ~(SOFT_W'(1) << soft_lvl);

    irq_soft_lvl #(.SOFT_W(SOFT_W), .LVL_W(LVL_W)) i_lvl_rest (
        .vec (soft_rest),
        .lvl (rest_lvl)
    );

    irq_pend_bank #(.N_SRC(NUM_SRC), .IDX_W(CODE_W)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .post_vld (post_vld),
        .post_idx (post_idx),
        .clr      (clr),
        .pend     (pend),
        .post_err (post_err)
    );

    irq_arbiter #(
        .N_SRC   (NUM_SRC),
        .LVL_W   (LVL_W),
        .PIL_W   (PIL_W),
        .TL_W    (TL_W),
        .VEC_LVL (VEC_LVL)
    ) i_arb (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .take_req  (take_req),
        .hpriv     (hpriv),
        .int_en    (int_en),
        .tl0_en    (tl0_en),
        .trap_lvl  (trap_lvl),
        .pil       (pil),
        .soft_lvl  (soft_lvl),
        .soft_more (rest_lvl != '0),
        .grant     (grant),
        .code      (code),
        .clr       (clr)
    );

    assign any_pend  = |pend;
    assign take_vld  = grant;
    assign take_code = grant ? code : '0;
    assign take_lvl  = (grant && code == SRC_SOFT) ? soft_lvl : '0;

    p_soft_lvl_top_r9: assert property (@(posedge clk) disable iff (rst)
        (soft_lvl != '0) |-> soft_reg[soft_lvl]);

    p_soft_lvl_none_r9: assert property (@(posedge clk) disable iff (rst)
        (soft_lvl == '0) |-> (soft_reg[SOFT_W-1:1] == '0));

    p_take_gated_r14: assert property (@(posedge clk) disable iff (rst)
        take_vld |-> (take_req && any_pend));
endmodule

// File: tb/test_irq_prio_sel.sv
module test_irq_prio_sel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_vld = 1'b0;
    logic [2:0]  post_idx = '0;
    logic        take_req = 1'b0;
    logic        hpriv = 1'b0;
    logic        int_en = 1'b0;
    logic        tl0_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [3:0]  pil = '0;
    logic [15:0] soft_reg = '0;
    logic        any_pend, post_err, take_vld;
    logic [2:0]  take_code;
    logic [3:0]  take_lvl;

    int n_chk = 0;
    int n_err = 0;
    bit [6:0] mp = '0;

    always #4 clk = ~clk;

    irq_prio_sel i_irq_prio_sel (
        .clk(clk), .rst(rst), .post_vld(post_vld), .post_idx(post_idx),
        .take_req(take_req), .hpriv(hpriv), .int_en(int_en), .tl0_en(tl0_en),
        .trap_lvl(trap_lvl), .pil(pil), .soft_reg(soft_reg),
        .any_pend(any_pend), .post_err(post_err), .take_vld(take_vld),
        .take_code(take_code), .take_lvl(take_lvl)
    );

    function automatic int lvl_of(logic [15:0] s);
        int l = 0;
        for (int i = 1; i < 16; i++) if (s[i]) l = i;
        return l;
    endfunction

    // Expected winner from the requirements, -1 when none qualifies.
    function automatic int pick(bit [6:0] p);
        int l = lvl_of(soft_reg);
        if (hpriv) begin
            if (!int_en) return -1;
            if (p[1]) return 1;
            if (p[2]) return 2;
            return -1;
        end
        if (p[0] && tl0_en && trap_lvl == 0) return 0;
        if (p[1]) return 1;
        if (!int_en) return -1;
        if (p[3]) return 3;
        if (p[4]) return 4;
        if (p[6] && l < 6 && p[2]) return 2;
        if (p[6] && l > int'(pil)) return 6;
        if (p[5]) return 5;
        return -1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        int c;
        int l;
        bit bad;
        #1;
        c   = take_req ? pick(mp) : -1;
        l   = lvl_of(soft_reg);
        bad = post_vld && post_idx == 3'd7;
        chk(tag, "any_pend", int'(any_pend), int'(mp != 0));
        chk(tag, "post_err", int'(post_err), int'(bad));
        chk(tag, "take_vld", int'(take_vld), int'(c >= 0));
        if (c >= 0) begin
            chk(tag, "take_code", int'(take_code), c);
            chk(tag, "take_lvl", int'(take_lvl), (c == 6) ? l : 0);
            if (c != 6 || lvl_of(soft_reg & ~(16'd1 << l)) == 0) mp[c] = 1'b0;
        end
        if (post_vld && !bad) mp[post_idx] = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        post_vld = 0; take_req = 0;
    endtask

    task automatic post(int idx, string tag);
        idle_in(); post_vld = 1; post_idx = 3'(idx);
        step(tag);
        post_vld = 0;
    endtask

    task automatic take(string tag);
        idle_in(); take_req = 1;
        step(tag);
        take_req = 0;
    endtask

    task automatic mode(bit hp, bit ie, bit t0, int tl, int pl, logic [15:0] sr);
        hpriv = hp; int_en = ie; tl0_en = t0;
        trap_lvl = 3'(tl); pil = 4'(pl); soft_reg = sr;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        mp  = '0;

        // R1: reset state, a request delivers nothing
        mode(0, 1, 1, 0, 0, 16'hFFFF);
        take("R1");
        // R3: illegal number flags an error and changes nothing
        post(7, "R3");
        take("R3");
        // R2, R8: message sources in order
        post(4, "R2"); post(3, "R2");
        take("R8"); take("R8");
        take("R4");
        // R5: hypervisor mode gating and order
        post(2, "R5"); post(1, "R5"); post(3, "R5");
        mode(1, 0, 0, 0, 0, 16'h0);
        take("R5");
        mode(1, 1, 0, 0, 0, 16'h0);
        take("R5"); take("R5"); take("R5");
        // R14: pending but no request
        idle_in(); step("R14");
        mode(0, 1, 0, 0, 0, 16'h0);
        take("R8");
        // R6: trap-level-zero gating
        post(0, "R6");
        mode(0, 1, 0, 0, 0, 16'h0); take("R6");
        mode(0, 1, 1, 2, 0, 16'h0); take("R6");
        mode(0, 1, 1, 0, 0, 16'h0); take("R6");
        // R7: timer delivered with interrupts disabled
        post(1, "R7");
        mode(0, 0, 0, 0, 0, 16'h0); take("R7");
        // R9, R12: soft flag held while other levels remain
        post(6, "R12");
        mode(0, 1, 0, 0, 2, 16'h0209);
        take("R9");
        idle_in(); step("R12");
        mode(0, 1, 0, 0, 2, 16'h0009);
        take("R12");
        idle_in(); step("R4");
        // R10: low soft level yields to vector; high level does not
        post(6, "R10"); post(2, "R10");
        mode(0, 1, 0, 0, 0, 16'h0010);
        take("R10");
        post(2, "R10");
        mode(0, 1, 0, 0, 0, 16'h0100);
        take("R10"); take("R10");
        mode(0, 1, 0, 0, 0, 16'h0000);
        take("R10");
        // R11: soft at or below PIL falls through to resumable error
        post(6, "R11"); post(5, "R11");
        mode(0, 1, 0, 0, 5, 16'h0008);
        take("R11");
        mode(0, 1, 0, 0, 5, 16'h0020);
        take("R11");
        mode(0, 1, 0, 0, 2, 16'h0008);
        take("R11");
        // R13: post and delivery on one source in one cycle
        post(3, "R13");
        mode(0, 1, 0, 0, 0, 16'h0);
        idle_in(); take_req = 1; post_vld = 1; post_idx = 3'd3;
        step("R13");
        idle_in();
        take("R13");
        idle_in(); step("R4");

        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            post_vld = ($urandom % 3) == 0;
            post_idx = 3'($urandom % 8);
            take_req = ($urandom % 2) == 1;
            hpriv    = ($urandom % 4) == 0;
            int_en   = ($urandom % 4) != 0;
            tl0_en   = ($urandom % 2) == 1;
            trap_lvl = 3'($urandom % 3);
            pil      = 4'($urandom % 16);
            soft_reg = 16'($urandom & $urandom);
            step("R8");
        end

        idle_in();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule